// File: doc/BRIEF.md
# Programmable Square-Wave Tap Selector

This block makes a square wave from a 32.768 kHz reference. The reference arrives as a level that has already been brought into the system clock domain. Each rising edge of that level advances a free-running 15-stage binary divider. A 4-bit rate code is decoded onto 15 one-hot lines, and each line picks one of 13 divider taps. The chosen counter bit drives the output pin, so every divided rate has a 50% duty cycle. An override bit sends the reference itself to the pin in place of a divided tap. An enable bit can hold the pin low.

A small state machine decides what the pin carries. It looks at the enable, the override and the rate code. It also looks at the power state: whether main power is present, whether auxiliary voltage is present, and whether the auxiliary-battery enable is set. With main power absent, the pin runs only in full-rate backup mode, and only when every backup condition is met.

The states are as follows:
- `ST_OFF`: the pin is held low.
- `ST_TAP`: the pin carries the divider tap.
- `ST_FULL`: the pin carries the reference, with main power present.
- `ST_BACKUP`: the pin carries the reference, on auxiliary power.

The next state is computed from the inputs on every cycle, so any state can move to any other state in one clock. There are four transitions into states:
- "disable" goes to `ST_OFF`.
- "select tap" goes to `ST_TAP`.
- "override" goes to `ST_FULL`.
- "fail over" goes to `ST_BACKUP`.

Top module: `sqw_tap_gen`

## Requirements
- R1: With main power present and `sqw_en`=0, `sqw_out` is 0 whatever the other inputs are.
- R2: With main power present, `sqw_en`=1 and `full_rate`=1, `sqw_out` follows the reference level for every value of `rate_sel`.
- R3: With main power present, `sqw_en`=1 and `full_rate`=0, a nonzero `rate_sel` code selects one divider bit (bit k is 32768/2^(k+1) Hz):
  - Codes 1 and 8 select bit 6 (256 Hz).
  - Codes 2 and 9 select bit 7 (128 Hz).
  - Codes 3 to 7 select bits 1 to 5 (8.192 kHz down to 512 Hz).
  - Codes 10 to 15 select bits 8 to 13 (64 Hz down to 2 Hz).
- R4: With main power present, `sqw_en`=1, `full_rate`=0 and `rate_sel`=0, `sqw_out` is 0.
- R5: With main power absent and `sqw_en`, `full_rate`, `aux_bat_en` and `aux_volt_ok` all 1, `sqw_out` follows the reference level.
- R6: With main power absent and any of those four inputs at 0, `sqw_out` is 0.
- R7: The divider counts rising edges of `ref_lvl` since reset. A change of rate code or mode never clears it, so the tap value always equals the selected bit of that count.
- R8: `sqw_out` reflects the reference level, and the rise count through that level, as `ref_lvl` stood 3 clocks earlier. It reflects a change of configuration input 2 clocks after the change.
- R9: During reset and right after it, `sqw_out` is 0 and the divider count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_lvl | input | 1 | 32.768 kHz reference level, already in the clk domain |
| sqw_en | input | 1 | Square-wave enable |
| full_rate | input | 1 | Override that sends the reference to the pin |
| rate_sel | input | 4 | Rate code |
| aux_bat_en | input | 1 | Permits backup operation |
| main_pwr_ok | input | 1 | Main power present |
| aux_volt_ok | input | 1 | Auxiliary voltage present |
| sqw_out | output | 1 | Square-wave pin level |

## Verification
A wrong tap decode or a divider that restarts shows at the pin within one half-period of the selected rate. The wrong bit, or a phase slip against the rise count kept by the bench, flips `sqw_out` at a cycle the count does not predict. A wrong mode decision shows two clocks after the inputs change, as a pin that stays low or that toggles when it should not. The bench follows every cycle of each phase with an exact model, so the first cycle that differs is reported.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

    localparam int RATE_W = 4;
    localparam int LINES  = (1 << RATE_W) - 1;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_TAP,
        ST_FULL,
        ST_BACKUP
    } sqw_state_e;

    // Divider bit driven by each decoded line (line 0 is never decoded).
    function automatic int tap_of(input int line);
        int b;
        case (line)
            1:       b = 6;
            2:       b = 7;
            3:       b = 1;
            4:       b = 2;
            5:       b = 3;
            6:       b = 4;
            7:       b = 5;
            8:       b = 6;
            9:       b = 7;
            10:      b = 8;
            11:      b = 9;
            12:      b = 10;
            13:      b = 11;
            14:      b = 12;
            15:      b = 13;
            default: b = 0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sqw_ref_sync.sv
module sqw_ref_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_lvl,
    output logic ref_dly,
    output logic tick
);
    logic stage1_q;
    logic stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else begin
            stage1_q <= ref_lvl;
            stage2_q <= stage1_q;
        end
    end

    assign tick    = stage1_q & ~stage2_q;
    assign ref_dly = stage2_q;
endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
    parameter int STAGES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [STAGES-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sqw_tap_decode.sv
module sqw_tap_decode
    import sqw_pkg::*;
#(
    parameter int STAGES = 15
) (
    input  logic [RATE_W-1:0] code,
    output logic [STAGES-1:0] tap_mask
);
    logic [LINES:1] line_sel;

    for (genvar l = 1; l <= LINES; l++) begin : g_line
        assign line_sel[l] = (code == RATE_W'(l));
    end

    always_comb begin
        tap_mask = '0;
        for (int l = 1; l <= LINES; l++) begin
            if (line_sel[l] && tap_of(l) < STAGES) begin
                tap_mask[tap_of(l)] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sqw_tap_gen.sv
module sqw_tap_gen
    import sqw_pkg::*;
#(
    parameter int STAGES = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_lvl,
    input  logic              sqw_en,
    input  logic              full_rate,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              aux_bat_en,
    input  logic              main_pwr_ok,
    input  logic              aux_volt_ok,
    output logic              sqw_out
);
    logic              ref_dly;
    logic              tick;
    logic [STAGES-1:0] div_cnt;
    logic [STAGES-1:0] tap_mask_d;
    logic [STAGES-1:0] tap_mask_q;
    sqw_state_e        state_d;
    sqw_state_e        state_q;
    logic              backup_ok;

    sqw_ref_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_lvl (ref_lvl),
        .ref_dly (ref_dly),
        .tick    (tick)
    );

    sqw_divider #(.STAGES(STAGES)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .count (div_cnt)
    );

    sqw_tap_decode #(.STAGES(STAGES)) u_dec (
        .code     (rate_sel),
        .tap_mask (tap_mask_d)
    );

    assign backup_ok = sqw_en & full_rate & aux_bat_en & aux_volt_ok;

    // Next-state decode: disable / select tap / override / fail over.
    always_comb begin
        if (!main_pwr_ok) begin
            state_d = backup_ok ? ST_BACKUP : ST_OFF;
        end else if (!sqw_en) begin
            state_d = ST_OFF;
        end else if (full_rate) begin
            state_d = ST_FULL;
        end else if (rate_sel == '0) begin
            state_d = ST_OFF;
        end else begin
            state_d = ST_TAP;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_OFF;
            tap_mask_q <= '0;
        end else begin
            state_q    <= state_d;
            tap_mask_q <= tap_mask_d;
        end
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sqw_out <= 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF:    sqw_out <= 1'b0;
                ST_TAP:    sqw_out <= |(div_cnt & tap_mask_q);
                ST_FULL:   sqw_out <= ref_dly;
                ST_BACKUP: sqw_out <= ref_dly;
                default:   sqw_out <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sqw_tap_gen_chk.sv
module sqw_tap_gen_chk #(
    parameter int STAGES = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_lvl,
    input logic              sqw_en,
    input logic              full_rate,
    input logic [3:0]        rate_sel,
    input logic              aux_bat_en,
    input logic              main_pwr_ok,
    input logic              aux_volt_ok,
    input logic              sqw_out,
    input logic              tick,
    input logic [STAGES-1:0] div_cnt
);
    logic [2:0] age;
    logic       warm;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 3'd7) begin
            age <= age + 3'd1;
        end
    end

    assign warm = (age >= 3'd4);

    AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(main_pwr_ok & ~sqw_en, 2)) |-> !sqw_out); // R1

    AST_FULL_FOLLOWS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(main_pwr_ok & sqw_en & full_rate, 2)) |-> (sqw_out == $past(ref_lvl, 3))); // R2

    AST_CODE_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(main_pwr_ok & sqw_en & ~full_rate & (rate_sel == 4'd0), 2)) |-> !sqw_out); // R4

    AST_BACKUP_FOLLOWS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(~main_pwr_ok & sqw_en & full_rate & aux_bat_en & aux_volt_ok, 2))
            |-> (sqw_out == $past(ref_lvl, 3))); // R5

    AST_NO_POWER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && $past(~main_pwr_ok & ~(sqw_en & full_rate & aux_bat_en & aux_volt_ok), 2))
            |-> !sqw_out); // R6

    AST_DIV_HOLDS_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && !$past(tick)) |-> $stable(div_cnt)); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(!rst_n) |-> (!sqw_out && div_cnt == '0)); // R9
endmodule

bind sqw_tap_gen sqw_tap_gen_chk #(.STAGES(STAGES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_lvl     (ref_lvl),
    .sqw_en      (sqw_en),
    .full_rate   (full_rate),
    .rate_sel    (rate_sel),
    .aux_bat_en  (aux_bat_en),
    .main_pwr_ok (main_pwr_ok),
    .aux_volt_ok (aux_volt_ok),
    .sqw_out     (sqw_out),
    .tick        (tick),
    .div_cnt     (div_cnt)
);

// File: tb/sqw_tap_gen_tb.sv
module sqw_tap_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_lvl = 1'b0;
    logic       sqw_en = 1'b0;
    logic       full_rate = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic       aux_bat_en = 1'b0;
    logic       main_pwr_ok = 1'b1;
    logic       aux_volt_ok = 1'b0;
    logic       sqw_out;

    always #10 clk = ~clk;

    sqw_tap_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_lvl     (ref_lvl),
        .sqw_en      (sqw_en),
        .full_rate   (full_rate),
        .rate_sel    (rate_sel),
        .aux_bat_en  (aux_bat_en),
        .main_pwr_ok (main_pwr_ok),
        .aux_volt_ok (aux_volt_ok),
        .sqw_out     (sqw_out)
    );

    int  n_total = 0;
    int  n_fail  = 0;
    bit  ref_run = 1'b0;
    bit  chk_on  = 1'b0;
    int  mism    = 0;
    int  first_act, first_exp;
    int  rises   = 0;
    int  h_ref  [1:3];
    int  h_rise [1:3];
    bit  finished = 1'b0;

    // Divider bit for a nonzero code (R3).
    function automatic int code_bit(input int code);
        return (code < 3) ? code + 5 : code - 2;
    endfunction

    // Expected pin value from the requirements and the history 3 clocks back (R8).
    function automatic int expect_pin();
        bit bk;
        if (!main_pwr_ok) begin
            bk = sqw_en & full_rate & aux_bat_en & aux_volt_ok;
            return bk ? h_ref[3] : 0;
        end
        if (!sqw_en) return 0;
        if (full_rate) return h_ref[3];
        if (rate_sel == 4'd0) return 0;
        return (h_rise[3] >> code_bit(int'(rate_sel))) & 1;
    endfunction

    initial begin
        for (int i = 1; i <= 3; i++) begin
            h_ref[i]  = 0;
            h_rise[i] = 0;
        end
    end

    always @(negedge clk) begin
        int e;
        if (chk_on) begin
            e = expect_pin();
            if (int'(sqw_out) != e) begin
                if (mism == 0) begin
                    first_act = int'(sqw_out);
                    first_exp = e;
                end
                mism++;
            end
        end
        h_ref[3]  = h_ref[2];
        h_ref[2]  = h_ref[1];
        h_rise[3] = h_rise[2];
        h_rise[2] = h_rise[1];
        if (ref_run) begin
            ref_lvl = ~ref_lvl;
            if (ref_lvl) rises++;
        end
        h_ref[1]  = int'(ref_lvl);
        h_rise[1] = rises;
    end

    task automatic check(input string what, input bit ok, input int act, input int exp_v);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp_v);
        end
    endtask

    task automatic run_phase(input string what, input int ncyc);
        chk_on = 1'b0;
        repeat (4) @(negedge clk);
        mism = 0;
        chk_on = 1'b1;
        repeat (ncyc) @(negedge clk);
        chk_on = 1'b0;
        check(what, mism == 0, first_act, first_exp);
    endtask

    task automatic set_cfg(input bit mp, input bit en, input bit fr, input int code,
                           input bit ab, input bit av);
        @(negedge clk);
        main_pwr_ok = mp;
        sqw_en      = en;
        full_rate   = fr;
        rate_sel    = 4'(code);
        aux_bat_en  = ab;
        aux_volt_ok = av;
    endtask

    initial begin
        int b;
        sqw_en   = 1'b1;
        rate_sel = 4'd3;
        repeat (3) @(negedge clk);
        check("R9 output low in reset", sqw_out == 1'b0, int'(sqw_out), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 output low after reset", sqw_out == 1'b0, int'(sqw_out), 0);
        ref_run = 1'b1;

        set_cfg(1, 0, 0, 3, 0, 0);
        run_phase("R1 disabled, code 3", 64);
        set_cfg(1, 0, 1, 9, 1, 1);
        run_phase("R1 disabled, override set", 64);

        set_cfg(1, 1, 0, 0, 0, 0);
        run_phase("R4 code 0", 64);

        for (int code = 1; code <= 15; code++) begin
            b = code_bit(code);
            set_cfg(1, 1, 0, code, 0, 0);
            run_phase($sformatf("R3 R7 R8 code %0d", code), (b < 4) ? 64 : (1 << (b + 2)));
        end

        set_cfg(1, 1, 0, 13, 0, 0);
        run_phase("R7 code 13 before switch", 3000);
        set_cfg(1, 1, 0, 5, 0, 0);
        run_phase("R7 code 5 after switch, no restart", 200);

        set_cfg(1, 1, 1, 0, 0, 0);
        run_phase("R2 override with code 0", 64);
        set_cfg(1, 1, 1, 9, 0, 0);
        run_phase("R2 R8 override with code 9", 64);

        set_cfg(0, 1, 1, 4, 1, 1);
        run_phase("R5 backup full rate", 64);

        for (int m = 0; m < 15; m++) begin
            set_cfg(0, m[3], m[2], 6, m[1], m[0]);
            run_phase($sformatf("R6 no main power, combo %0d", m), 32);
        end

        set_cfg(1, 1, 0, 3, 0, 0);
        run_phase("R8 back to code 3 after power return", 64);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end
endmodule